// File: doc/BRIEF.md
# Gapless Multichannel Serial Word Transmitter

This block takes a frame of fixed-width samples, one word per channel, and sends it out as one unbroken serial stream. Each word is sent most significant bit first, and the channels go out in ascending order. The words follow each other with no idle bit period between them. Two marker outputs show where the data sits in the frame. The word marker is high on the first bit of every word. The frame marker is high only on the first bit of channel 0. A receiver can therefore find word and frame boundaries without any chip-select toggling.

The bit rate is the system clock divided by `CLKS_PER_BIT`. A strobe, `bit_clk_en`, pulses on the first clock of each bit period, and the data and markers are stable for the whole period.

New frames come in through a valid/ready interface that takes one transfer per frame. `frm_ready` pulses for a single clock, which is the final clock of the last bit of the last channel. A transfer happens only in that clock. A producer that holds `frm_valid` while `frm_ready` is low simply waits, and the data it presents in the meantime is ignored. When no transfer happens at the frame boundary, the stored frame is sent again. Back-pressure never stalls the stream.

Top module: `gapless_word_tx`

## Requirements
- R1: While reset is held and in the first clock after it is released, the block shows the first bit of channel 0: `bit_clk_en`=1, `word_mark`=1, `frame_mark`=1, `ser_bit`=0 and `frm_ready`=0. Until the first frame is accepted, an all-zero frame is transmitted.
- R2: `bit_clk_en` is high for exactly one clock in every `CLKS_PER_BIT` clocks (default 2), with no missing or extra strobes at word or frame boundaries.
- R3: `ser_bit`, `word_mark` and `frame_mark` hold their value on every clock of a bit period that is not its strobe clock.
- R4: A frame is `CHANNELS`×`WORD_W` consecutive bit periods. Channel c is `frm_data[c*WORD_W +: WORD_W]`. Channels are sent in order 0 to `CHANNELS`-1, each word MSB first, with no gap between words or frames.
- R5: `word_mark` is high during exactly the first bit period of every word.
- R6: `frame_mark` is high only during the first bit period of channel 0.
- R7: `frm_ready` is high only on the last clock of the last bit of channel `CHANNELS`-1. A transfer in that clock makes the accepted channel 0 MSB appear on the next clock.
- R8: `frm_data` is ignored unless `frm_valid` and `frm_ready` are both high. Data presented earlier in a frame while valid waits does not appear in the stream.
- R9: When no transfer happens at a frame boundary, the previously stored frame is sent again unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frm_valid | input | 1 | Producer offers a frame |
| frm_data | input | CHANNELS*WORD_W | Frame, channel c at bits c*WORD_W upward |
| frm_ready | output | 1 | One-clock transfer window at frame end |
| bit_clk_en | output | 1 | Strobe on the first clock of each bit period |
| ser_bit | output | 1 | Serial data bit |
| word_mark | output | 1 | First bit of a word |
| frame_mark | output | 1 | First bit of channel 0 |

## Verification
The tightest cycle is the frame boundary, where three things happen on one clock edge: the transfer, the capture into the frame register, and the loading of the first word of the next frame into the shifter. The bench provokes it in three ways. It holds valid through whole frames, it drops valid so the stored frame repeats, and it sends two frames back to back. A scoreboard builds the expected bit of every period from the frames it has seen accepted, and flags any period where a stale frame's channel 0 appears, a bit is doubled, or a strobe goes missing around the wrap.

// File: rtl/gwt_pkg.sv
package gwt_pkg;
  // Width of an index able to address 'n' items (minimum one bit).
  function automatic int idx_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  // Position of the active bit inside the frame.
  typedef struct packed {
    logic word_end;
    logic frame_end;
  } gwt_pos_t;
endpackage

// File: rtl/gwt_prescaler.sv
module gwt_prescaler #(
  parameter int CLKS_PER_BIT = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic bit_stb,
  output logic bit_end
);
  import gwt_pkg::*;
  localparam int PW = idx_w(CLKS_PER_BIT);

  generate
    if (CLKS_PER_BIT == 1) begin : g_full_rate
      assign bit_stb = 1'b1;
      assign bit_end = 1'b1;
    end else begin : g_divided
      logic [PW-1:0] cnt_q;
      always_ff @(posedge clk) begin
        if (!rst_n)       cnt_q <= '0;
        else if (bit_end) cnt_q <= '0;
        else              cnt_q <= cnt_q + 1'b1;
      end
      assign bit_stb = (cnt_q == '0);
      assign bit_end = (cnt_q == PW'(CLKS_PER_BIT - 1));

      // R2: a period's last clock is always followed by a strobe
      p_stb_follows_end_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bit_end |=> bit_stb);
      // R2: no two strobes back to back when the period is longer than a clock
      p_no_double_stb_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bit_stb |=> !bit_stb);
    end
  endgenerate
endmodule

// File: rtl/gwt_sequencer.sv
module gwt_sequencer #(
  parameter int CHANNELS = 8,
  parameter int WORD_W   = 16
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                bit_end,
  output logic [gwt_pkg::idx_w(CHANNELS)-1:0] ch_idx,
  output gwt_pkg::gwt_pos_t                   pos,
  output logic                                word_mark,
  output logic                                frame_mark
);
  import gwt_pkg::*;
  localparam int BW = idx_w(WORD_W);
  localparam int CW = idx_w(CHANNELS);
  localparam logic [BW-1:0] LAST_BIT = BW'(WORD_W - 1);
  localparam logic [CW-1:0] LAST_CH  = CW'(CHANNELS - 1);

  logic [BW-1:0] bit_q;
  logic [CW-1:0] ch_q;

  assign pos.word_end  = bit_end && (bit_q == LAST_BIT);
  assign pos.frame_end = pos.word_end && (ch_q == LAST_CH);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bit_q <= '0;
      ch_q  <= '0;
    end else if (pos.word_end) begin
      bit_q <= '0;
      ch_q  <= (ch_q == LAST_CH) ? '0 : ch_q + 1'b1;
    end else if (bit_end) begin
      bit_q <= bit_q + 1'b1;
    end
  end

  assign ch_idx     = ch_q;
  assign word_mark  = (bit_q == '0);
  assign frame_mark = word_mark && (ch_q == '0);

  // R5: the end of one word starts the next with the word marker
  p_word_mark_after_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pos.word_end |=> word_mark);
  // R6: a frame wrap lands on the frame marker
  p_frame_mark_after_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pos.frame_end |=> frame_mark);
  // R6: a non-final word end never lands on the frame marker
  p_no_mid_frame_mark_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pos.word_end && !pos.frame_end) |=> !frame_mark);
endmodule

// File: rtl/gwt_frame_store.sv
module gwt_frame_store #(
  parameter int CHANNELS = 8,
  parameter int WORD_W   = 16
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                frm_valid,
  input  logic [CHANNELS*WORD_W-1:0]          frm_data,
  input  logic [gwt_pkg::idx_w(CHANNELS)-1:0] ch_idx,
  input  gwt_pkg::gwt_pos_t                   pos,
  output logic                                frm_ready,
  output logic [WORD_W-1:0]                   next_word
);
  import gwt_pkg::*;
  localparam int CW = idx_w(CHANNELS);
  localparam int FW = CHANNELS * WORD_W;
  localparam logic [CW-1:0] LAST_CH = CW'(CHANNELS - 1);

  logic [FW-1:0]     frame_q;
  logic [WORD_W-1:0] words [CHANNELS];
  logic [CW-1:0]     next_idx;
  logic              accept;

  generate
    for (genvar c = 0; c < CHANNELS; c++) begin : g_unpack
      assign words[c] = frame_q[c*WORD_W +: WORD_W];
    end
  endgenerate

  assign frm_ready = pos.frame_end;
  assign accept    = frm_valid && frm_ready;
  assign next_idx  = (ch_idx == LAST_CH) ? '0 : ch_idx + 1'b1;

  always_comb begin
    if (pos.frame_end)
      next_word = accept ? frm_data[WORD_W-1:0] : words[0];
    else
      next_word = words[next_idx];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      frame_q <= '0;
    else if (accept) frame_q <= frm_data;
  end

  // R8 / R9: the stored frame changes only through a transfer
  p_frame_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> $stable(frame_q));
  // R7: a transfer stores the offered frame
  p_frame_captured_r7: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (frame_q == $past(frm_data)));
endmodule

// File: rtl/gwt_shifter.sv
module gwt_shifter #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_end,
  input  logic              word_end,
  input  logic [WORD_W-1:0] next_word,
  output logic              ser_bit
);
  logic [WORD_W-1:0] sh_q;

  always_ff @(posedge clk) begin
    if (!rst_n)        sh_q <= '0;
    else if (word_end) sh_q <= next_word;
    else if (bit_end)  sh_q <= {sh_q[WORD_W-2:0], 1'b0};
  end

  assign ser_bit = sh_q[WORD_W-1];

  // R3: the output bit holds until a period ends
  p_bit_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_end |=> $stable(ser_bit));
  // R4: the first bit after a reload is the new word's MSB
  p_msb_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
    word_end |=> (ser_bit == $past(next_word[WORD_W-1])));
endmodule

// File: rtl/gapless_word_tx.sv
module gapless_word_tx #(
  parameter int CHANNELS     = 8,
  parameter int WORD_W       = 16,
  parameter int CLKS_PER_BIT = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       frm_valid,
  input  logic [CHANNELS*WORD_W-1:0] frm_data,
  output logic                       frm_ready,
  output logic                       bit_clk_en,
  output logic                       ser_bit,
  output logic                       word_mark,
  output logic                       frame_mark
);
  import gwt_pkg::*;
  localparam int CW = idx_w(CHANNELS);

  logic              bit_end;
  logic [CW-1:0]     ch_idx;
  gwt_pos_t          pos;
  logic [WORD_W-1:0] next_word;

  gwt_prescaler #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_presc (
    .clk(clk), .rst_n(rst_n), .bit_stb(bit_clk_en), .bit_end(bit_end));

  gwt_sequencer #(.CHANNELS(CHANNELS), .WORD_W(WORD_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .bit_end(bit_end), .ch_idx(ch_idx), .pos(pos),
    .word_mark(word_mark), .frame_mark(frame_mark));

  gwt_frame_store #(.CHANNELS(CHANNELS), .WORD_W(WORD_W)) u_store (
    .clk(clk), .rst_n(rst_n), .frm_valid(frm_valid), .frm_data(frm_data),
    .ch_idx(ch_idx), .pos(pos), .frm_ready(frm_ready), .next_word(next_word));

  gwt_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .bit_end(bit_end), .word_end(pos.word_end),
    .next_word(next_word), .ser_bit(ser_bit));

  // R7: the clock after the ready window starts a new frame on a strobe
  p_ready_then_frame_r7: assert property (@(posedge clk) disable iff (!rst_n)
    frm_ready |=> (frame_mark && bit_clk_en));
  // R6: the frame marker only ever accompanies the word marker
  p_frame_within_word_r6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_mark |-> word_mark);
  // R3: markers keep their value between strobes
  p_marks_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_end |=> ($stable(word_mark) && $stable(frame_mark)));
endmodule

// File: tb/gapless_word_tx_bench.sv
module gapless_word_tx_bench;
  localparam int CH  = 8;
  localparam int WW  = 16;
  localparam int CPB = 2;
  localparam int FW  = CH * WW;
  localparam int NB  = CH * WW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          frm_valid = 1'b0;
  logic [FW-1:0] frm_data = '0;
  logic          frm_ready, bit_clk_en, ser_bit, word_mark, frame_mark;

  int n_chk = 0;
  int n_bad = 0;
  logic [FW-1:0] exp_q [$];
  bit mon_run = 1'b0;

  always #5 clk = ~clk;

  gapless_word_tx #(.CHANNELS(CH), .WORD_W(WW), .CLKS_PER_BIT(CPB)) u_gapless_word_tx (
    .clk(clk), .rst_n(rst_n), .frm_valid(frm_valid), .frm_data(frm_data),
    .frm_ready(frm_ready), .bit_clk_en(bit_clk_en), .ser_bit(ser_bit),
    .word_mark(word_mark), .frame_mark(frame_mark));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [FW-1:0] mk_frame(input int seed);
    logic [FW-1:0] f;
    for (int c = 0; c < CH; c++)
      f[c*WW +: WW] = WW'((seed * 16'h1357) ^ (c * 16'h0F1E) ^ (c << 12) ^ seed);
    return f;
  endfunction

  // Driver: offer a frame, optionally with early junk data that must be ignored (R8)
  task automatic send_frame(input logic [FW-1:0] f, input bit junk_first);
    @(negedge clk);
    frm_valid = 1'b1;
    if (junk_first) begin
      frm_data = ~f;
      repeat (40) @(negedge clk);
    end
    frm_data = f;
    while (!frm_ready) @(negedge clk);
    @(posedge clk);
    exp_q.push_back(f);
    @(negedge clk);
    frm_valid = 1'b0;
    frm_data  = ~f;
  endtask

  // Monitor / scoreboard: one sample per clock, away from the active edge
  task automatic monitor();
    int fb = 0;
    int ph = 0;
    bit first = 1'b1;
    logic [FW-1:0] cur = '0;
    logic h_bit = 1'b0, h_wm = 1'b0, h_fm = 1'b0;
    while (mon_run) begin
      if (bit_clk_en) begin
        if (!first) begin
          chk(ph == CPB - 1, "R2 strobe spacing", ph + 1, CPB);
          fb = (fb + 1) % NB;
        end
        first = 1'b0;
        ph = 0;
        if (fb == 0 && exp_q.size() > 0) cur = exp_q.pop_front();  // R9 repeat if empty
        begin
          int c = fb / WW;
          int b = fb % WW;
          logic e_bit = cur[c*WW + WW - 1 - b];
          chk(ser_bit == e_bit, "R4 serial bit", ser_bit, e_bit);
          chk(word_mark == (b == 0), "R5 word_mark", word_mark, b == 0);
          chk(frame_mark == (fb == 0), "R6 frame_mark", frame_mark, fb == 0);
        end
        h_bit = ser_bit; h_wm = word_mark; h_fm = frame_mark;
      end else begin
        ph++;
        chk(ph < CPB, "R2 missing strobe", ph, CPB - 1);
        chk(ser_bit == h_bit && word_mark == h_wm && frame_mark == h_fm,
            "R3 hold within period", {ser_bit, word_mark, frame_mark},
            {h_bit, h_wm, h_fm});
      end
      chk(frm_ready == (fb == NB - 1 && ph == CPB - 1), "R7 ready window",
          frm_ready, fb == NB - 1 && ph == CPB - 1);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1: reset state
    chk(bit_clk_en == 1'b1, "R1 reset strobe", bit_clk_en, 1);
    chk(word_mark == 1'b1, "R1 reset word_mark", word_mark, 1);
    chk(frame_mark == 1'b1, "R1 reset frame_mark", frame_mark, 1);
    chk(ser_bit == 1'b0, "R1 reset data", ser_bit, 0);
    chk(frm_ready == 1'b0, "R1 reset ready", frm_ready, 0);
    rst_n = 1'b1;
    mon_run = 1'b1;
    fork monitor(); join_none
    // R1: first frame after reset is all zero (checked by monitor), A waits for it
    send_frame(mk_frame(1), 1'b0);
    // R8: junk offered early in the frame must not be taken
    send_frame(mk_frame(2), 1'b1);
    // R9: no offer for a while -> frame 2 repeats
    repeat (3 * NB * CPB) @(negedge clk);
    // R7: back-to-back transfers with valid held, edge patterns
    send_frame('1, 1'b0);
    send_frame({(FW/2){2'b10}}, 1'b0);
    send_frame(mk_frame(7), 1'b1);
    repeat (2 * NB * CPB + 8) @(negedge clk);
    chk(exp_q.size() == 0, "R7 all offered frames accepted", exp_q.size(), 0);
    mon_run = 1'b0;
    @(negedge clk);
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule